// File: doc/BRIEF.md
# Packed Unsigned Saturating Add/Subtract Unit

This block is a SIMD integer datapath for a processor execute stage. Two 32-bit operand words arrive from the register file. They are split into either two 16-bit halfword lanes or four 8-bit byte lanes. Each lane is then added or subtracted with unsigned saturation: an add that overflows sticks at all ones, and a subtract that would go negative sticks at zero. Two mixed modes swap the halfwords of the second operand first, and then add in one lane and subtract in the other.

The unit takes the raw 32-bit instruction word. From it, the unit extracts the operation selector, the two source register indices and the destination index. The source indices go out straight away so the register file can be read in the same cycle. Every issued operation produces a valid strobe, so the pipeline retires it and the program counter advances. The destination write enable is raised only when the condition field says "always", or when the external condition-pass input is true.

A parameter selects whether result, destination index, write enable and valid are registered together (one cycle of latency) or leave the unit combinationally.

Top module: `pkd_usat_unit`

## Requirements
- R1: The operation is taken from instruction bits [7:5]. The codes are: 0 halfword add, 1 exchange add/subtract, 2 exchange subtract/add, 3 halfword subtract, 4 byte add. Codes 5, 6 and 7 all select byte subtract.
- R2: A saturating lane add returns the lane's all-ones value (0xFF for a byte, 0xFFFF for a halfword) when the true sum does not fit the lane. Otherwise it returns the sum.
- R3: A saturating lane subtract returns 0 when the first operand lane is less than or equal to the second. Otherwise it returns the difference.
- R4: Code 1 gives result[15:0] = sat_sub(A[15:0], B[31:16]) and result[31:16] = sat_add(A[31:16], B[15:0]).
- R5: Code 2 gives result[15:0] = sat_add(A[15:0], B[31:16]) and result[31:16] = sat_sub(A[31:16], B[15:0]).
- R6: In byte modes, each of the four byte lanes is computed on its own, with no carry or borrow between lanes, and stays in its own position. In the non-exchange halfword modes, the low halfwords pair with each other and the high halfwords pair with each other.
- R7: The operand A index is instruction bits [19:16] and the operand B index is bits [3:0]; both are output combinationally. The destination index is bits [15:12].
- R8: When the condition field (instruction bits [31:28]) is 0xE, the write enable is raised for an issued operation whatever the condition-pass input. For any other field value, the write enable follows the condition-pass input.
- R9: Every issued operation raises valid, including one whose condition fails. A cycle with no issue raises neither valid nor the write enable.
- R10: With the output register enabled (the default), result, destination index, write enable and valid appear together one clock after issue. While reset is held, valid, the write enable and the result are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| issue_i | input | 1 | An instruction is presented this cycle |
| instr_i | input | 32 | Raw instruction word |
| cond_pass_i | input | 1 | External condition evaluation result |
| opa_i | input | 32 | Operand A value (register at A index) |
| opb_i | input | 32 | Operand B value (register at B index) |
| src_a_idx_o | output | 4 | Register index for operand A |
| src_b_idx_o | output | 4 | Register index for operand B |
| rslt_o | output | 32 | Packed saturated result |
| dst_idx_o | output | 4 | Destination register index |
| wr_en_o | output | 1 | Destination write enable |
| valid_o | output | 1 | Operation retired (program counter advances) |

## Verification
On every cycle, the assertions check the control side of the unit: that valid follows issue one cycle later, that a write enable never appears without valid, that the "always" condition forces a write, that a failed condition drops the write while keeping valid, and that the destination index is carried through. One datapath property also runs on every cycle: a halfword subtract of equal operands must give zero. The full lane arithmetic can only be shown by the bench scenarios, which compare the result against a behavioural model. These scenarios cover the saturation bounds in both lane sizes, equal operands, the crossing in both exchange modes, independence between byte lanes, and random vectors under every selector code.

// File: rtl/pkd_usat_pkg.sv
package pkd_usat_pkg;
  localparam int INSTR_W = 32;
  localparam int IDX_W   = 4;
  localparam int SEL_W   = 3;

  localparam int COND_LSB = 28;
  localparam int SRCA_LSB = 16;
  localparam int DST_LSB  = 12;
  localparam int SEL_LSB  = 5;
  localparam int SRCB_LSB = 0;

  localparam logic [3:0] COND_ALWAYS = 4'hE;

  typedef enum logic [SEL_W-1:0] {
    OP_ADD16   = 3'd0,
    OP_ADDSUBX = 3'd1,
    OP_SUBADDX = 3'd2,
    OP_SUB16   = 3'd3,
    OP_ADD8    = 3'd4,
    OP_SUB8    = 3'd5
  } op_e;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic [IDX_W-1:0] a_idx;
    logic [IDX_W-1:0] b_idx;
    logic [IDX_W-1:0] d_idx;
    logic             always_ex;
  } dec_t;
endpackage

// File: rtl/pkd_usat_decode.sv
module pkd_usat_decode
  import pkd_usat_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output dec_t               dec_o
);
  logic unused_bits;
  assign unused_bits = ^{instr_i[27:20], instr_i[11:8], instr_i[4]};

  always_comb begin
    dec_o.sel       = instr_i[SEL_LSB  +: SEL_W];
    dec_o.a_idx     = instr_i[SRCA_LSB +: IDX_W];
    dec_o.b_idx     = instr_i[SRCB_LSB +: IDX_W];
    dec_o.d_idx     = instr_i[DST_LSB  +: IDX_W];
    dec_o.always_ex = (instr_i[COND_LSB +: 4] == COND_ALWAYS);
  end
endmodule

// File: rtl/pkd_usat_lane.sv
module pkd_usat_lane #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] y_o
);
  logic [W:0] sum, dif;

  always_comb begin
    sum = {1'b0, a_i} + {1'b0, b_i};
    dif = {1'b0, a_i} - {1'b0, b_i};
    if (sub_i) y_o = dif[W] ? '0 : dif[W-1:0];  // borrow clamps to zero
    else       y_o = sum[W] ? '1 : sum[W-1:0];  // carry clamps to all ones
  end
endmodule

// File: rtl/pkd_usat_dp.sv
module pkd_usat_dp
  import pkd_usat_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] y_o
);
  localparam int HALF_W = DATA_W / 2;
  localparam int BYTE_W = 8;
  localparam int BYTE_N = DATA_W / BYTE_W;

  logic [DATA_W-1:0] y_half, y_byte;
  logic exch, byte_mode;

  assign exch      = (sel_i == OP_ADDSUBX) || (sel_i == OP_SUBADDX);
  assign byte_mode = sel_i[2];

  for (genvar h = 0; h < 2; h++) begin : g_half
    logic [HALF_W-1:0] b_sel;
    logic              sub;
    assign b_sel = exch ? b_i[(1-h)*HALF_W +: HALF_W] : b_i[h*HALF_W +: HALF_W];
    if (h == 0) begin : g_lo
      assign sub = (sel_i == OP_ADDSUBX) || (sel_i == OP_SUB16);
    end else begin : g_hi
      assign sub = (sel_i == OP_SUBADDX) || (sel_i == OP_SUB16);
    end
    pkd_usat_lane #(.W(HALF_W)) i_lane (
      .a_i  (a_i[h*HALF_W +: HALF_W]),
      .b_i  (b_sel),
      .sub_i(sub),
      .y_o  (y_half[h*HALF_W +: HALF_W])
    );
  end

  for (genvar g = 0; g < BYTE_N; g++) begin : g_byte
    pkd_usat_lane #(.W(BYTE_W)) i_lane (
      .a_i  (a_i[g*BYTE_W +: BYTE_W]),
      .b_i  (b_i[g*BYTE_W +: BYTE_W]),
      .sub_i(sel_i != OP_ADD8),
      .y_o  (y_byte[g*BYTE_W +: BYTE_W])
    );
  end

  assign y_o = byte_mode ? y_byte : y_half;
endmodule

// File: rtl/pkd_usat_unit.sv
module pkd_usat_unit
  import pkd_usat_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_i,
  input  logic [31:0]       instr_i,
  input  logic              cond_pass_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  output logic [3:0]        src_a_idx_o,
  output logic [3:0]        src_b_idx_o,
  output logic [DATA_W-1:0] rslt_o,
  output logic [3:0]        dst_idx_o,
  output logic              wr_en_o,
  output logic              valid_o
);
  dec_t              dec;
  logic [DATA_W-1:0] res_c;
  logic              wr_c;

  pkd_usat_decode i_dec (.instr_i(instr_i), .dec_o(dec));

  pkd_usat_dp #(.DATA_W(DATA_W)) i_dp (
    .sel_i(dec.sel),
    .a_i  (opa_i),
    .b_i  (opb_i),
    .y_o  (res_c)
  );

  assign src_a_idx_o = dec.a_idx;
  assign src_b_idx_o = dec.b_idx;
  assign wr_c        = issue_i & (dec.always_ex | cond_pass_i);

  if (OUT_REG) begin : g_reg
    logic [DATA_W-1:0] res_q;
    logic [3:0]        dst_q;
    logic              wr_q, vld_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        res_q <= '0;
        dst_q <= '0;
        wr_q  <= 1'b0;
        vld_q <= 1'b0;
      end else begin
        vld_q <= issue_i;
        wr_q  <= wr_c;
        if (issue_i) begin
          res_q <= res_c;
          dst_q <= dec.d_idx;
        end
      end
    end
    assign rslt_o    = res_q;
    assign dst_idx_o = dst_q;
    assign wr_en_o   = wr_q;
    assign valid_o   = vld_q;
  end else begin : g_comb
    assign rslt_o    = res_c;
    assign dst_idx_o = dec.d_idx;
    assign wr_en_o   = wr_c;
    assign valid_o   = issue_i;
  end
endmodule

// File: rtl/pkd_usat_chk.sv
module pkd_usat_chk #(
  parameter int DATA_W  = 32,
  parameter bit OUT_REG = 1'b1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              issue_i,
  input logic [31:0]       instr_i,
  input logic              cond_pass_i,
  input logic [DATA_W-1:0] opa_i,
  input logic [DATA_W-1:0] opb_i,
  input logic [DATA_W-1:0] rslt_o,
  input logic [3:0]        dst_idx_o,
  input logic              wr_en_o,
  input logic              valid_o
);
  if (OUT_REG) begin : g_seq
    p_valid_follows_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      issue_i |=> valid_o);
    p_idle_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !issue_i |=> (!valid_o && !wr_en_o));
    p_always_writes_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (issue_i && instr_i[31:28] == 4'hE) |=> wr_en_o);
    p_fail_no_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (issue_i && instr_i[31:28] != 4'hE && !cond_pass_i) |=> (valid_o && !wr_en_o));
    p_dst_carried_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      issue_i |=> (dst_idx_o == $past(instr_i[15:12])));
    p_sub_equal_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (issue_i && instr_i[7:5] == 3'd3 && opa_i == opb_i) |=> (rslt_o == '0));
    p_wr_needs_valid_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_o |-> valid_o);
  end else begin : g_cmb
    always_comb begin
      if (rst_ni) begin
        a_wr_needs_valid_r9: assert (!wr_en_o || valid_o);
        a_always_writes_r8: assert (!(issue_i && instr_i[31:28] == 4'hE) || wr_en_o);
      end
    end
  end
endmodule

bind pkd_usat_unit pkd_usat_chk #(.DATA_W(DATA_W), .OUT_REG(OUT_REG)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .issue_i(issue_i), .instr_i(instr_i),
  .cond_pass_i(cond_pass_i), .opa_i(opa_i), .opb_i(opb_i), .rslt_o(rslt_o),
  .dst_idx_o(dst_idx_o), .wr_en_o(wr_en_o), .valid_o(valid_o)
);

// File: tb/test_pkd_usat_unit.sv
`timescale 1ns/1ps
module test_pkd_usat_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue = 1'b0;
  logic [31:0] instr = '0;
  logic        cpass = 1'b0;
  logic [31:0] opa = '0, opb = '0;
  logic [3:0]  a_idx, b_idx, d_idx;
  logic [31:0] rslt;
  logic        wr_en, vld;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #2.5 clk = ~clk;

  pkd_usat_unit i_pkd_usat_unit (
    .clk_i(clk), .rst_ni(rst_n), .issue_i(issue), .instr_i(instr),
    .cond_pass_i(cpass), .opa_i(opa), .opb_i(opb),
    .src_a_idx_o(a_idx), .src_b_idx_o(b_idx), .rslt_o(rslt),
    .dst_idx_o(d_idx), .wr_en_o(wr_en), .valid_o(vld)
  );

  // expectation pushed per driven cycle, compared one clock later
  typedef struct {
    bit          vld;
    bit          wr;
    logic [31:0] res;
    logic [3:0]  dst;
    string       tag;
  } exp_t;
  exp_t q[$];

  function automatic int sadd(int x, int y, int w);
    int m = (1 << w) - 1;
    return (x + y > m) ? m : x + y;
  endfunction

  function automatic int ssub(int x, int y);
    return (x <= y) ? 0 : x - y;
  endfunction

  function automatic logic [31:0] model(int sel, logic [31:0] a, logic [31:0] b);
    int al = int'(a[15:0]), ah = int'(a[31:16]);
    int bl = int'(b[15:0]), bh = int'(b[31:16]);
    int lo, hi;
    logic [31:0] r;
    case (sel)
      0: begin lo = sadd(al, bl, 16); hi = sadd(ah, bh, 16); end
      1: begin lo = ssub(al, bh);     hi = sadd(ah, bl, 16); end
      2: begin lo = sadd(al, bh, 16); hi = ssub(ah, bl);     end
      3: begin lo = ssub(al, bl);     hi = ssub(ah, bh);     end
      default: begin lo = 0; hi = 0; end
    endcase
    r = {hi[15:0], lo[15:0]};
    if (sel >= 4) begin
      for (int k = 0; k < 4; k++) begin
        int x = int'(a[8*k +: 8]);
        int y = int'(b[8*k +: 8]);
        int z = (sel == 4) ? sadd(x, y, 8) : ssub(x, y);
        r[8*k +: 8] = z[7:0];
      end
    end
    return r;
  endfunction

  function automatic string sel_tag(int sel);
    case (sel)
      0: return "R2";
      1: return "R4";
      2: return "R5";
      3: return "R3";
      4: return "R6";
      default: return "R1";
    endcase
  endfunction

  function automatic logic [31:0] mk(logic [3:0] c, int sel, logic [3:0] ai,
                                     logic [3:0] bi, logic [3:0] di);
    logic [2:0] s = sel[2:0];
    return {c, 8'h66, ai, di, 4'hF, s, 1'b1, bi};
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare_prev();
    exp_t e;
    if (q.size() == 0) return;
    e = q.pop_front();
    chk(vld === e.vld, "R9", "valid", {31'b0, vld}, {31'b0, e.vld});
    chk(wr_en === e.wr, "R8", "write enable", {31'b0, wr_en}, {31'b0, e.wr});
    if (e.vld) begin
      chk(rslt === e.res, e.tag, "result", rslt, e.res);
      chk(d_idx === e.dst, "R7", "dest index", {28'b0, d_idx}, {28'b0, e.dst});
    end
  endtask

  // one cycle: compare previous, drive new, check comb index outputs, queue expectation
  task automatic cyc(bit iss, logic [3:0] c, int sel, bit cp,
                     logic [31:0] a, logic [31:0] b, string tag_ovr);
    exp_t e;
    logic [3:0] ai = 4'($urandom), bi = 4'($urandom), di = 4'($urandom);
    @(negedge clk);
    compare_prev();
    issue = iss; instr = mk(c, sel, ai, bi, di); cpass = cp; opa = a; opb = b;
    #1;
    chk({a_idx, b_idx} === {ai, bi}, "R7", "source indices",
        {24'b0, a_idx, b_idx}, {24'b0, ai, bi});
    e.vld = iss;
    e.wr  = iss && (c == 4'hE || cp);
    e.res = model(sel, a, b);
    e.dst = di;
    e.tag = (tag_ovr != "") ? tag_ovr : sel_tag(sel);
    q.push_back(e);
  endtask

  initial begin
    #(5.0 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({vld, wr_en} === 2'b00 && rslt === '0, "R10", "reset state",
        {rslt[29:0], vld, wr_en}, 32'h0);
    rst_n = 1'b1;

    // halfword saturation bounds
    cyc(1, 4'hE, 0, 0, 32'hFFFF_0001, 32'h0001_FFFF, "R2");
    cyc(1, 4'hE, 0, 0, 32'h8000_7FFF, 32'h7FFF_8000, "R2");
    cyc(1, 4'hE, 3, 0, 32'h1234_0000, 32'h1234_0001, "R3");
    cyc(1, 4'hE, 3, 0, 32'h0000_FFFF, 32'hFFFF_FFFE, "R3");
    // exchange modes
    cyc(1, 4'hE, 1, 0, 32'hFFF0_0005, 32'h0010_0009, "R4");
    cyc(1, 4'hE, 1, 0, 32'h0003_9000, 32'h0004_1000, "R4");
    cyc(1, 4'hE, 2, 0, 32'h0005_FFF0, 32'h0010_0009, "R5");
    cyc(1, 4'hE, 2, 0, 32'h9000_0003, 32'h1000_0004, "R5");
    // byte lanes: no carry or borrow across lanes
    cyc(1, 4'hE, 4, 0, 32'hFF01_80FF, 32'h01FF_8001, "R6");
    cyc(1, 4'hE, 5, 0, 32'h0010_FF00, 32'h0100_FF01, "R6");
    cyc(1, 4'hE, 4, 0, 32'h0000_0000, 32'h0000_0000, "R6");
    // selector codes 6 and 7 act as byte subtract
    cyc(1, 4'hE, 6, 0, 32'h8040_2010, 32'h1020_4080, "R1");
    cyc(1, 4'hE, 7, 0, 32'hFFFF_FFFF, 32'h0102_0304, "R1");
    // condition handling
    cyc(1, 4'h0, 0, 0, 32'h1, 32'h2, "R8");
    cyc(1, 4'h0, 0, 1, 32'h1, 32'h2, "R8");
    cyc(1, 4'hE, 3, 0, 32'h5, 32'h3, "R8");
    cyc(1, 4'hF, 4, 0, 32'h5, 32'h3, "R9");
    cyc(0, 4'hE, 0, 1, 32'h5, 32'h3, "R9");
    // back-to-back latency
    cyc(1, 4'hE, 0, 0, 32'h0001_0001, 32'h0001_0001, "R10");
    cyc(1, 4'hE, 3, 0, 32'h0003_0003, 32'h0001_0001, "R10");

    for (int i = 0; i < 2000; i++) begin
      int sel = int'($urandom_range(0, 7));
      logic [3:0] c = ($urandom_range(0, 1) == 0) ? 4'hE : 4'($urandom);
      cyc($urandom_range(0, 3) != 0, c, sel, bit'($urandom), $urandom, $urandom, "");
    end
    cyc(0, 4'hE, 0, 0, 32'h0, 32'h0, "R9");
    @(negedge clk);
    compare_prev();

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule